// File: doc/BRIEF.md
# Serial ADC Channel-Read Controller

This block is an SPI master that fetches conversion results from a multi-channel serial ADC. Each read is one fixed 12-bit frame. A client offers a channel number on a valid/ready request port. The controller then builds a command word and runs a framed transfer with three states: a chip-select setup cycle, a shift phase, and a one-cycle closing sync state. The shift phase sends the command out and, over the same serial clocks, collects the converter's reply. The reply appears on a result port together with a one-cycle valid strobe.

The request side follows valid/ready rules. `req_ready` is high only while the controller is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. A client that holds `req_valid` simply waits, and any request offered while `req_ready` is low has no effect. The result side has no back-pressure: `res_valid` is a single-cycle strobe, so the consumer must capture `res_data` and `res_chan` in that cycle.

The serial clock is generated from the system clock and idles low. Each half period is `HALF_DIV` system cycles long. MOSI changes after falling edges, and MISO is sampled at rising edges. A converter of this type answers each command with the result of the command before it, so the result port also reports the channel that was requested in the previous frame.

Top module: `spi_adc_reader`

## Requirements
- R1: After reset, the block is idle: `spi_csn`=1, `spi_mosi`=1, `spi_sclk`=0, `res_valid`=0 and `req_ready`=1.
- R2: `req_ready` is high only while idle. A request is accepted when `req_valid` and `req_ready` are both high, and that channel is latched. Requests offered while `req_ready` is low start no frame and do not change the frame in progress.
- R3: The command is `{chan[3:0], CFG_BITS[3:0], 4'b1111}`, sent MSB first over exactly 12 rising edges of `spi_sclk` per frame.
- R4: In the cycle after acceptance, `spi_csn` is 0, `spi_mosi` is 1 and `spi_sclk` is 0. This chip-select setup state lasts exactly one system cycle.
- R5: `spi_sclk` is low whenever `spi_csn` is high. Each half period lasts `HALF_DIV` system cycles. `spi_mosi` changes only while `spi_sclk` is low.
- R6: The MISO bit sampled at the k-th rising edge (k = 0..11) is stored at bit 11-k of `res_data`.
- R7: After the last falling edge, the block enters a sync state with `spi_csn`=1 and `spi_mosi`=1. `res_valid` is then high for exactly one cycle with the new `res_data`.
- R8: `res_chan` gives the channel of the frame before the current one. For the first frame after reset it is 0.
- R9: With `req_valid` held high on one channel, frames follow each other with `res_valid` pulses 3 + 24*`HALF_DIV` cycles apart, and each frame returns correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_chan | input | 4 | Channel number of the request |
| spi_csn | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial command out, parked high |
| spi_miso | input | 1 | Serial reply in |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | 12 | Reply captured in the frame |
| res_chan | output | 4 | Channel requested in the prior frame |

## Verification
Single frames are run on channels 0, 1, 10 and 15. Channels 0 and 1 differ only in the lowest channel bit, which exposes a shifted or misplaced channel field. Channel 10's asymmetric pattern reveals a reversed bit order in either direction, and channel 15 shows whether the padding is kept apart from the channel nibble. A frame with a stray request offered mid-transfer shows that busy requests are dropped. A held-valid run on one channel checks the frame spacing and the one-frame lag of the reported channel.

// File: rtl/spi_adc_pkg.sv
package spi_adc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CS   = 2'd1,
    ST_DATA = 2'd2,
    ST_SYNC = 2'd3
  } frame_state_t;
endpackage

// File: rtl/spi_adc_sclk_gen.sv
module spi_adc_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q;
  logic          sclk_q;
  logic          half_end;

  assign half_end = (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!en) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (half_end) begin
      div_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  assign sclk      = sclk_q;
  assign rise_tick = en & half_end & ~sclk_q;
  assign fall_tick = en & half_end & sclk_q;

  // R5
  sclk_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sclk_q);
endmodule

// File: rtl/spi_adc_frame_fsm.sv
module spi_adc_frame_fsm
  import spi_adc_pkg::*;
#(
  parameter int FRAME_LEN = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         fall_tick,
  output logic                         req_ready,
  output logic                         accept,
  output frame_state_t                 state,
  output logic [$clog2(FRAME_LEN)-1:0] bit_idx,
  output logic                         frame_end
);
  localparam int CW = $clog2(FRAME_LEN);
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_LEN - 1);

  frame_state_t  state_q;
  logic [CW-1:0] bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          bit_q <= '0;
          if (req_valid) state_q <= ST_CS;
        end
        ST_CS:   state_q <= ST_DATA;
        ST_DATA: begin
          if (fall_tick) begin
            if (bit_q == LAST_BIT) state_q <= ST_SYNC;
            else                   bit_q   <= bit_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign state     = state_q;
  assign bit_idx   = bit_q;
  assign frame_end = (state_q == ST_DATA) & fall_tick & (bit_q == LAST_BIT);

  // R2
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && state_q != ST_IDLE) |=> state_q != ST_CS);
endmodule

// File: rtl/spi_adc_shift.sv
module spi_adc_shift #(
  parameter int FRAME_LEN = 12,
  parameter int CH_W      = 4,
  parameter int CFG_W     = 4,
  parameter logic [CFG_W-1:0] CFG_BITS = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         accept,
  input  logic [CH_W-1:0]              req_chan,
  input  logic                         shifting,
  input  logic [$clog2(FRAME_LEN)-1:0] bit_idx,
  input  logic                         rise_tick,
  input  logic                         frame_end,
  input  logic                         spi_miso,
  output logic                         mosi_bit,
  output logic [FRAME_LEN-1:0]         res_data,
  output logic [CH_W-1:0]              res_chan
);
  localparam int CW    = $clog2(FRAME_LEN);
  localparam int PAD_W = FRAME_LEN - CH_W - CFG_W;
  localparam logic [CW-1:0] TOP_BIT = CW'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] cmd_q;
  logic [FRAME_LEN-1:0] rx_q;
  logic [FRAME_LEN-1:0] res_q;
  logic [CH_W-1:0]      prev_chan_q;
  logic [CH_W-1:0]      res_chan_q;
  logic [CW-1:0]        rev_idx;

  assign rev_idx = TOP_BIT - bit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q       <= '1;
      rx_q        <= '0;
      res_q       <= '0;
      prev_chan_q <= '0;
      res_chan_q  <= '0;
    end else begin
      if (accept)
        cmd_q <= {req_chan, CFG_BITS, {PAD_W{1'b1}}};
      if (shifting && rise_tick)
        rx_q[rev_idx] <= spi_miso;
      if (frame_end) begin
        res_q       <= rx_q;
        res_chan_q  <= prev_chan_q;
        prev_chan_q <= cmd_q[FRAME_LEN-1 -: CH_W];
      end
    end
  end

  assign mosi_bit = cmd_q[rev_idx];
  assign res_data = res_q;
  assign res_chan = res_chan_q;
endmodule

// File: rtl/spi_adc_reader.sv
module spi_adc_reader
  import spi_adc_pkg::*;
#(
  parameter int FRAME_LEN = 12,
  parameter int CH_W      = 4,
  parameter int CFG_W     = 4,
  parameter int HALF_DIV  = 2,
  parameter logic [CFG_W-1:0] CFG_BITS = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [CH_W-1:0]      req_chan,
  output logic                 spi_csn,
  output logic                 spi_sclk,
  output logic                 spi_mosi,
  input  logic                 spi_miso,
  output logic                 res_valid,
  output logic [FRAME_LEN-1:0] res_data,
  output logic [CH_W-1:0]      res_chan
);
  localparam int CW = $clog2(FRAME_LEN);

  frame_state_t  state;
  logic          accept;
  logic [CW-1:0] bit_idx;
  logic          frame_end;
  logic          rise_tick;
  logic          fall_tick;
  logic          shifting;
  logic          mosi_bit;

  assign shifting = (state == ST_DATA);

  spi_adc_frame_fsm #(.FRAME_LEN(FRAME_LEN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fall_tick(fall_tick),
    .req_ready(req_ready), .accept(accept), .state(state),
    .bit_idx(bit_idx), .frame_end(frame_end)
  );

  spi_adc_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk(clk), .rst_n(rst_n), .en(shifting),
    .sclk(spi_sclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  spi_adc_shift #(
    .FRAME_LEN(FRAME_LEN), .CH_W(CH_W), .CFG_W(CFG_W), .CFG_BITS(CFG_BITS)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_chan(req_chan),
    .shifting(shifting), .bit_idx(bit_idx), .rise_tick(rise_tick),
    .frame_end(frame_end), .spi_miso(spi_miso), .mosi_bit(mosi_bit),
    .res_data(res_data), .res_chan(res_chan)
  );

  assign spi_csn   = !((state == ST_CS) || (state == ST_DATA));
  assign spi_mosi  = shifting ? mosi_bit : 1'b1;
  assign res_valid = (state == ST_SYNC);

  // R5
  csn_sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> !spi_sclk);

  // R5
  mosi_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_csn && !$stable(spi_mosi)) |-> !spi_sclk);

  // R4
  cs_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_csn) |-> (spi_mosi && !spi_sclk));

  // R7
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R7
  res_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (spi_csn && spi_mosi));
endmodule

// File: tb/spi_adc_reader_tb.sv
module spi_adc_reader_tb;
  localparam logic [3:0] CFG = 4'h6;
  localparam int HDIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_chan = 4'h0;
  logic        spi_csn, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b1;
  logic        res_valid;
  logic [11:0] res_data;
  logic [3:0]  res_chan;

  int total = 0;
  int bad = 0;

  logic [11:0] reply_q = 12'h000;
  logic [11:0] sl_out = 12'h000;
  logic [11:0] rx_cmd = 12'h000;
  int          rise_cnt = 0;
  int          sl_k = 0;
  logic [3:0]  prev_chan = 4'h0;
  int          frame_no = 0;

  always #5 clk = ~clk;

  spi_adc_reader #(.HALF_DIV(HDIV), .CFG_BITS(CFG)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .res_valid(res_valid),
    .res_data(res_data), .res_chan(res_chan)
  );

  // converter model: reply shifts out from chip-select fall, one bit per falling edge
  always @(negedge spi_csn) begin
    sl_out   = reply_q;
    rx_cmd   = 12'h000;
    rise_cnt = 0;
    sl_k     = 0;
    spi_miso = sl_out[11];
  end
  always @(posedge spi_sclk) if (!spi_csn) begin
    rx_cmd   = {rx_cmd[10:0], spi_mosi};
    rise_cnt = rise_cnt + 1;
  end
  always @(negedge spi_sclk) if (!spi_csn) begin
    sl_k = sl_k + 1;
    if (sl_k < 12) spi_miso = sl_out[11 - sl_k];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] reply_for(input logic [3:0] pc, input int n);
    return {pc, 8'(8'h5A ^ n[7:0])};
  endfunction

  task automatic wait_result(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (res_valid) begin seen = 1'b1; break; end
    end
    if (!seen) chk("R7 result timeout", 0, 1);
  endtask

  task automatic check_result(input logic [3:0] ch, input string tag);
    chk({tag, " R3 command"}, 32'(rx_cmd), 32'({ch, CFG, 4'hF}));
    chk({tag, " R3 clock count"}, rise_cnt, 12);
    chk({tag, " R6 data"}, 32'(res_data), 32'(reply_q));
    chk({tag, " R8 channel"}, 32'(res_chan), 32'(prev_chan));
    chk({tag, " R7 csn/mosi"}, {spi_csn, spi_mosi}, 2'b11);
  endtask

  task automatic start_req(input logic [3:0] ch);
    reply_q = reply_for(prev_chan, frame_no);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_chan  = ch;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R4 setup csn/mosi/sclk", {spi_csn, spi_mosi, spi_sclk}, 3'b010);
    chk("R2 ready low busy", req_ready, 0);
    @(negedge clk);
    chk("R4 setup one cycle (sclk low, data state)", {spi_csn, spi_sclk}, 2'b00);
  endtask

  task automatic single_frame(input logic [3:0] ch);
    bit seen;
    start_req(ch);
    wait_result(seen);
    if (seen) begin
      check_result(ch, "single");
      @(negedge clk);
      chk("R7 valid one cycle", res_valid, 0);
    end
    prev_chan = ch;
    frame_no++;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {spi_csn, spi_mosi, spi_sclk, res_valid, req_ready}, 5'b11001);
  endtask

  task automatic t_busy_ignore();
    bit seen;
    start_req(4'h3);
    repeat (10) @(negedge clk);
    req_valid = 1'b1;
    req_chan  = 4'h9;
    @(negedge clk);
    req_valid = 1'b0;
    req_chan  = 4'h0;
    wait_result(seen);
    if (seen) check_result(4'h3, "R2 busy");
    prev_chan = 4'h3;
    frame_no++;
    begin
      int low_seen = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (!spi_csn || res_valid) low_seen++;
      end
      chk("R2 no frame from busy request", low_seen, 0);
    end
  endtask

  task automatic t_back_to_back(input logic [3:0] ch);
    bit seen;
    int gap;
    reply_q = reply_for(prev_chan, frame_no);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_chan  = ch;
    for (int f = 0; f < 3; f++) begin
      gap = 0;
      seen = 1'b0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        gap++;
        if (res_valid) begin seen = 1'b1; break; end
      end
      if (!seen) chk("R9 result timeout", 0, 1);
      else begin
        check_result(ch, "R9 repeat");
        if (f > 0) chk("R9 frame spacing", gap, 3 + 24 * HDIV);
      end
      prev_chan = ch;
      frame_no++;
      reply_q = reply_for(prev_chan, frame_no);
      if (f == 2) req_valid = 1'b0;
    end
    @(negedge clk);
    @(negedge clk);
    chk("R9 stop after release", {spi_csn, req_ready}, 2'b11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    single_frame(4'h0);
    single_frame(4'h1);
    single_frame(4'hA);
    single_frame(4'hF);
    t_busy_ignore();
    t_back_to_back(4'h5);
    single_frame(4'h2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule